// File: doc/BRIEF.md
# Key-Press Edge Interrupt Controller

This block watches four port pins used as keys. When one of them shows the edge chosen for it, the block raises a single shared interrupt request. Each key has an enable bit and a polarity bit. The eight bits sit in one control register on a small register bus. A key takes part only while its port direction bit marks the pin as an input.

The qualified key levels are first turned into active-high form. They are then ORed into one merged line. That line drives a wake-up output directly, with no clock in the path, so it can end a low-power mode while the clock is stopped. A synchronized copy of the merged line feeds a rising-edge detector, and that detector sets a sticky request flag.

Software reads the flag through a status address and clears it by writing 1 to bit 0. The flag reaches the interrupt output only while the mask input allows it. The key settings should be changed only while the interrupt is masked. After such a change, software clears the flag and then unmasks the interrupt.

Top module: `keyin_irq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, the request flag is 0, `irq_req` is 0 and `wake` is 0.
- R2: A write to address 0 stores all 8 bits, and a read of address 0 returns them. For key i, bit 2i is the enable bit and bit 2i+1 is the polarity bit.
- R3: A key contributes only when its `port_dir` bit is 1 (input) and its enable bit is 1. Otherwise its pin has no effect on the flag or on `wake`.
- R4: Polarity 0 makes low the active level, so a falling edge is detected. Polarity 1 makes high the active level, so a rising edge is detected. The opposite edge never sets the flag.
- R5: While any contributing key is held at its active level, edges on the other keys do not set the flag.
- R6: A pin change that makes the merged line active sets the flag on the third rising clock edge after the change, and not before.
- R7: The flag stays set until a write to address 1 with bit 0 equal to 1. A write there with bit 0 equal to 0 leaves the flag unchanged.
- R8: When a new detected edge and a clear write fall on the same clock edge, the flag ends up set.
- R9: `irq_req` is 1 exactly when the flag is 1 and `irq_en` is 1. An edge that arrives while `irq_en` is 0 still sets the flag.
- R10: `wake` is 1 whenever any contributing key sits at its active level. It follows the pins with no clock edge needed.
- R11: A read of address 1 returns the flag in bit 0 and zeros in bits 7 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_pin | input | 4 | Raw key pin levels |
| port_dir | input | 4 | Port direction per pin, 1 means input |
| irq_en | input | 1 | Interrupt mask, 1 lets the request out |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 is control, 1 is status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Key interrupt request |
| wake | output | 1 | Combinational wake-up from the merged key line |

## Verification
Register writes take effect on the clock edge that samples the strobe. The bench reads them back at the following falling edge. A key change is driven at a falling edge. The bench then confirms the flag is still clear after two rising edges and set after the third, which gives two synchronizer stages plus the flag register. The set-versus-clear test places the clear write on exactly that third edge. `wake` and `irq_req` are combinational, so they are checked one nanosecond after their inputs move, and `wake` is also checked with the clock halted.

// File: rtl/keyin_pkg.sv
package keyin_pkg;
    localparam int unsigned KEY_COUNT_DEF = 4;
    localparam int unsigned SYNC_DEPTH_DEF = 2;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
    localparam int unsigned STAT_FLAG_BIT = 0;
endpackage

// File: rtl/keyin_regs.sv
module keyin_regs
    import keyin_pkg::*;
#(
    parameter int unsigned NUM_KEYS = KEY_COUNT_DEF,
    localparam int unsigned CFG_W = 2 * NUM_KEYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [CFG_W-1:0]    bus_wdata,
    input  logic                flag,
    output logic [CFG_W-1:0]    cfg,
    output logic [NUM_KEYS-1:0] key_en,
    output logic [NUM_KEYS-1:0] key_rise,
    output logic                clr_req,
    output logic [CFG_W-1:0]    bus_rdata
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == ADDR_CTRL) begin
            st_d.cfg = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Per-key field split: enable at even bit, polarity at odd bit
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_fields
        assign key_en[k]   = st_q.cfg[2*k];
        assign key_rise[k] = st_q.cfg[2*k+1];
    end

    assign cfg     = st_q.cfg;
    assign clr_req = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[STAT_FLAG_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = st_q.cfg;
        end else begin
            bus_rdata[STAT_FLAG_BIT] = flag;
        end
    end
endmodule

// File: rtl/keyin_merge.sv
module keyin_merge
    import keyin_pkg::*;
#(
    parameter int unsigned NUM_KEYS = KEY_COUNT_DEF
) (
    input  logic [NUM_KEYS-1:0] key_pin,
    input  logic [NUM_KEYS-1:0] port_dir,
    input  logic [NUM_KEYS-1:0] key_en,
    input  logic [NUM_KEYS-1:0] key_rise,
    output logic                merged
);
    logic [NUM_KEYS-1:0] key_act;

    // Normalize each pin to active-high, then qualify by direction and enable
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic lvl_hi;
        assign lvl_hi     = key_pin[k] ^ ~key_rise[k];
        assign key_act[k] = lvl_hi & key_en[k] & port_dir[k];
    end

    assign merged = |key_act;
endmodule

// File: rtl/keyin_edge.sv
module keyin_edge
    import keyin_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    typedef struct packed {
        logic [SYNC_DEPTH-1:0] sync;
        logic                  prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_DEPTH-2:0], din};
        st_d.prev = st_q.sync[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.sync[SYNC_DEPTH-1] & ~st_q.prev;
endmodule

// File: rtl/keyin_flag.sv
module keyin_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/keyin_irq_ctrl.sv
module keyin_irq_ctrl
    import keyin_pkg::*;
#(
    parameter int unsigned NUM_KEYS   = KEY_COUNT_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
    localparam int unsigned CFG_W = 2 * NUM_KEYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_pin,
    input  logic [NUM_KEYS-1:0] port_dir,
    input  logic                irq_en,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [CFG_W-1:0]    bus_wdata,
    output logic [CFG_W-1:0]    bus_rdata,
    output logic                irq_req,
    output logic                wake
);
    logic [CFG_W-1:0]    cfg_w;
    logic [NUM_KEYS-1:0] en_w;
    logic [NUM_KEYS-1:0] rise_w;
    logic                clr_w;
    logic                flag_w;
    logic                merged_w;
    logic                edge_w;

    keyin_regs #(.NUM_KEYS(NUM_KEYS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (flag_w),
        .cfg       (cfg_w),
        .key_en    (en_w),
        .key_rise  (rise_w),
        .clr_req   (clr_w),
        .bus_rdata (bus_rdata)
    );

    keyin_merge #(.NUM_KEYS(NUM_KEYS)) u_merge (
        .key_pin  (key_pin),
        .port_dir (port_dir),
        .key_en   (en_w),
        .key_rise (rise_w),
        .merged   (merged_w)
    );

    keyin_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (merged_w),
        .pulse (edge_w)
    );

    keyin_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (edge_w),
        .clr   (clr_w),
        .flag  (flag_w)
    );

    assign wake    = merged_w;
    assign irq_req = flag_w & irq_en;
endmodule

// File: rtl/keyin_irq_chk.sv
module keyin_irq_chk #(
    parameter int unsigned NUM_KEYS = 4,
    localparam int unsigned CFG_W = 2 * NUM_KEYS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [CFG_W-1:0] bus_wdata,
    input logic [CFG_W-1:0] cfg,
    input logic             flag,
    input logic             edge_pulse,
    input logic             clr_req,
    input logic             irq_en,
    input logic             irq_req,
    input logic             wake
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg == '0 && !flag));

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> (cfg == $past(bus_wdata)));

    // R3
    idle_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == '0) |-> !wake);

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(edge_pulse));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !edge_pulse) |=> !flag);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> flag);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_en && flag));
endmodule

bind keyin_irq_ctrl keyin_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cfg        (cfg_w),
    .flag       (flag_w),
    .edge_pulse (edge_w),
    .clr_req    (clr_w),
    .irq_en     (irq_en),
    .irq_req    (irq_req),
    .wake       (wake)
);

// File: tb/keyin_irq_ctrl_bench.sv
`timescale 1ns/1ps
module keyin_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic [3:0] key_pin = 4'hF;
    logic [3:0] port_dir = 4'h0;
    logic       irq_en = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic       wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    keyin_irq_ctrl u_keyin_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_pin   (key_pin),
        .port_dir  (port_dir),
        .irq_en    (irq_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .wake      (wake)
    );

    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    // fields: [20:17] dir, [16:9] cfg, [8:5] pins before, [4:1] pins after, [0] flag expected
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {4'hF, 8'h01, 4'hF, 4'hE, 1'b1},  // R4 key0 falling
        {4'hF, 8'h03, 4'h0, 4'h1, 1'b1},  // R4 key0 rising
        {4'hF, 8'h03, 4'hF, 4'hE, 1'b0},  // R4 wrong edge for rising key0
        {4'hD, 8'h04, 4'hF, 4'hD, 1'b0},  // R3 key1 pin is output
        {4'hF, 8'h01, 4'hF, 4'hD, 1'b0},  // R3 key1 not enabled
        {4'hF, 8'hC0, 4'h0, 4'h8, 1'b1},  // R4 key3 rising
        {4'hF, 8'h05, 4'hE, 4'hC, 1'b0},  // R5 key0 held low blocks key1
        {4'hF, 8'h05, 4'hF, 4'hD, 1'b1},  // R5 no blocker, key1 falls
        {4'hF, 8'hD0, 4'h4, 4'h0, 1'b1},  // R4 key2 falling, key3 idle low
        {4'hF, 8'hD0, 4'hC, 4'h8, 1'b0}   // R5 key3 held high blocks key2
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 status", v, 8'h00);
        chk("R1 irq_req", {7'b0, irq_req}, 8'h00);
        chk("R1 wake", {7'b0, wake}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register layout readback
        wr(1'b0, 8'hA5);
        rd(1'b0, v); chk("R2 readback", v, 8'hA5);
        wr(1'b0, 8'h00);
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h01);

        // vector table
        for (int i = 0; i < NV; i++) begin
            port_dir = VEC[i][20:17];
            key_pin  = VEC[i][8:5];
            wr(1'b0, VEC[i][16:9]);
            repeat (5) @(negedge clk);
            wr(1'b1, 8'h01);
            key_pin = VEC[i][4:1];
            @(posedge clk); @(posedge clk); @(negedge clk);
            rd(1'b1, v); chk($sformatf("R6 early vec%0d", i), v, 8'h00);
            @(negedge clk);
            rd(1'b1, v); chk($sformatf("R3/R4/R5 vec%0d", i), v, {7'b0, VEC[i][0]});
            chk($sformatf("R9 irq vec%0d", i), {7'b0, irq_req}, {7'b0, VEC[i][0]});
        end

        // R7 and R11: sticky flag, write of 0 ignored, write of 1 clears
        port_dir = 4'hF; key_pin = 4'hF;
        wr(1'b0, 8'h01);
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h01);
        key_pin = 4'hE;
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R11 status byte", v, 8'h01);
        key_pin = 4'hF;
        wr(1'b1, 8'hFE);
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R7 zero write keeps flag", v, 8'h01);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R7 clear", v, 8'h00);

        // R8 set and clear on the same edge
        repeat (3) @(negedge clk);
        key_pin = 4'hE;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h01;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        rd(1'b1, v); chk("R8 set wins", v, 8'h01);
        key_pin = 4'hF;
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h01);

        // R9 masked edge still sets flag
        irq_en = 1'b0;
        key_pin = 4'hE;
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R9 masked flag", v, 8'h01);
        chk("R9 masked irq", {7'b0, irq_req}, 8'h00);
        irq_en = 1'b1;
        #1;
        chk("R9 unmasked irq", {7'b0, irq_req}, 8'h01);
        key_pin = 4'hF;
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h01);

        // R10 wake with the clock halted
        clk_run = 1'b0;
        #20;
        chk("R10 wake idle", {7'b0, wake}, 8'h00);
        key_pin = 4'hE;
        #20;
        chk("R10 wake no clock", {7'b0, wake}, 8'h01);
        port_dir = 4'hE;
        #1;
        chk("R10 R3 wake output pin", {7'b0, wake}, 8'h00);
        port_dir = 4'hF;
        key_pin = 4'hF;
        clk_run = 1'b1;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule